// File: doc/BRIEF.md
# Retriggerable Frame Delay Timer

This block measures a fixed delay from an external reference event and then raises a strobe that can start a response frame. It holds a 16-bit up-counter that advances only in cycles where the carrier-derived clock enable is high. A falling edge on the asynchronous event input is first synchronized and then restarts the count from zero. A software trigger or a start command does the same. While the counter runs, each new count value is compared with two registers. Reaching compare A drives the waveform output high. Reaching compare C drives it low and halts the counter at that value.

Three sticky status flags record compare A, compare C and external-trigger events. A read strobe clears them. An interrupt line is the OR of the compare-C and external-trigger flags, each gated by its own enable.

A slot helper takes requests on a valid/ready stream. Each request carries a reference count and a slot length. The helper captures the live count when the request is accepted and computes count + len − ((count − ref) mod len) + 3·len, with all arithmetic modulo 2^16. It returns the result on a second valid/ready stream. A sequential divider produces one remainder bit per cycle, so a request is busy for 16 cycles. Back-pressure works in both directions. The request side is ready only while the helper is idle. A result stays valid and unchanged until the consumer takes it, and no new request is accepted until then.

Top module: `fdt_timer`

## Requirements
- R1: After reset, the count is 0, the counter is stopped, the waveform output is low, the status is 0, irq is low, slot_req_ready is 1 and slot_rsp_valid is 0. Compare C resets to 0xFFFF and compare A resets to 0.
- R2: A high sw_trig or start_cmd in a cycle sets the count to 0 and starts the counter at the next edge. This applies whether the counter was running or stopped.
- R3: While running and not being triggered, the count rises by exactly 1 at each edge where carrier_tick is high. It holds when carrier_tick is low.
- R4: A falling edge on ext_event passes through two synchronizer flops and an edge detector, then restarts the count at 0 and drives the waveform output low. The restart appears three edges after the input falls. Rising edges of ext_event have no effect.
- R5: When the count steps onto the value of compare A, the waveform output goes high and status bit 0 is set.
- R6: When the count steps onto the value of compare C, the waveform output goes low, the counter stops and holds that value, and status bit 1 is set. If A equals C, the output ends low.
- R7: A stopped counter ignores carrier_tick. The count and the waveform output stay unchanged until a trigger arrives.
- R8: Status bits are bit 0 = compare A, bit 1 = compare C and bit 2 = external trigger. They are sticky, and status_rd clears them at the next edge. An event in the same cycle as the read stays set.
- R9: irq is high exactly when (status bit 1 and irq_en bit 0) or (status bit 2 and irq_en bit 1).
- R10: A write of compare A or compare C takes effect from the next cycle's compare onward, including while the counter runs.
- R11: A slot request is accepted at an edge where slot_req_valid and slot_req_ready are both high. After 16 more edges, slot_rsp_valid rises with count + len − ((count − ref) mod len) + 3·len mod 2^16. Here count is the counter value in the accepting cycle.
- R12: slot_rsp_valid and slot_rsp_value hold until slot_rsp_ready is high at an edge. slot_req_ready stays low from acceptance until the result is taken.
- R13: A slot length of 0 returns the reference value.
- R14: sw_trig drives the waveform output low. start_cmd leaves the waveform output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | Carrier-cycle enable; the counter advances only in these cycles |
| ext_event | input | 1 | Asynchronous reference event; its falling edge restarts the count |
| sw_trig | input | 1 | Software trigger: restart the count and drive the output low |
| start_cmd | input | 1 | Clock-enable command: restart the count from zero |
| cmp_a_we | input | 1 | Write strobe for compare A |
| cmp_a_val | input | 16 | New compare A value |
| cmp_c_we | input | 1 | Write strobe for compare C |
| cmp_c_val | input | 16 | New compare C value |
| irq_en | input | 2 | Interrupt enables: bit 0 compare C, bit 1 external trigger |
| status_rd | input | 1 | Status read strobe; clears the sticky flags |
| status | output | 3 | Sticky flags {ext trigger, compare C, compare A} |
| irq | output | 1 | Interrupt request |
| count | output | 16 | Current counter value |
| counting | output | 1 | Counter running |
| wave_out | output | 1 | Waveform output; its rising edge starts a response frame |
| slot_req_valid | input | 1 | Slot request valid |
| slot_req_ready | output | 1 | Slot request ready |
| slot_ref | input | 16 | Reference count for the slot request |
| slot_len | input | 16 | Slot length |
| slot_rsp_valid | output | 1 | Slot result valid |
| slot_rsp_ready | input | 1 | Slot result ready |
| slot_rsp_value | output | 16 | Next aligned slot count |

## Verification
The hardest case to reach from the ports is the counter halting at the default compare C of 0xFFFF. This requires more than 65,000 uninterrupted carrier ticks with no trigger, so one long run keeps carrier_tick high from a single start command. The other hard cases are coincidences: a status read landing in the same cycle as a synchronized external edge, and a slot request accepted while the count moves and the result is held back. Both are reached by placing ext_event edges and slot_rsp_ready stalls at fixed cycle offsets. A behavioural model predicts every output in every cycle.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  localparam int unsigned ST_CMPA = 0;
  localparam int unsigned ST_CMPC = 1;
  localparam int unsigned ST_ETRG = 2;
  localparam int unsigned ST_W    = 3;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_BUSY = 2'd1,
    SLOT_DONE = 2'd2
  } slot_state_e;
endpackage

// File: rtl/fdt_edge_sync.sv
module fdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign fall_pulse = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/fdt_count_core.sv
module fdt_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ext_fall,
  input  logic             sw_trig,
  input  logic             start_cmd,
  input  logic             a_we,
  input  logic [CNT_W-1:0] a_val,
  input  logic             c_we,
  input  logic [CNT_W-1:0] c_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             wave,
  output logic             hit_a,
  output logic             hit_c
);
  localparam logic [CNT_W-1:0] C_RESET = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cmp_a_q;
  logic [CNT_W-1:0] cmp_c_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             run_q;
  logic             wave_q;
  logic             restart;
  logic             force_low;
  logic             advance;

  assign restart   = ext_fall | sw_trig | start_cmd;
  assign force_low = ext_fall | sw_trig;
  assign advance   = run_q & tick & ~restart;
  assign cnt_inc   = cnt_q + ONE;
  assign hit_a     = advance & (cnt_inc == cmp_a_q);
  assign hit_c     = advance & (cnt_inc == cmp_c_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_c_q <= C_RESET;
    end else begin
      if (a_we) cmp_a_q <= a_val;
      if (c_we) cmp_c_q <= c_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (advance) begin
      cnt_q <= cnt_inc;
      if (hit_c) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         wave_q <= 1'b0;
    else if (force_low) wave_q <= 1'b0;
    else if (hit_c)     wave_q <= 1'b0;
    else if (hit_a)     wave_q <= 1'b1;
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign wave    = wave_q;
endmodule

// File: rtl/fdt_status.sv
module fdt_status
  import fdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_a,
  input  logic            ev_c,
  input  logic            ev_ext,
  input  logic            rd,
  input  logic [1:0]      ien,
  output logic [ST_W-1:0] flags,
  output logic            irq
);
  logic [ST_W-1:0] flags_q;
  logic [ST_W-1:0] events;

  always_comb begin
    events          = '0;
    events[ST_CMPA] = ev_a;
    events[ST_CMPC] = ev_c;
    events[ST_ETRG] = ev_ext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  flags_q <= '0;
    else if (rd) flags_q <= events;
    else         flags_q <= flags_q | events;
  end

  assign flags = flags_q;
  assign irq   = (flags_q[ST_CMPC] & ien[0]) | (flags_q[ST_ETRG] & ien[1]);
endmodule

// File: rtl/fdt_slot_calc.sv
module fdt_slot_calc
  import fdt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] ref_in,
  input  logic [W-1:0] len_in,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_value
);
  localparam int unsigned STEP_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(W - 1);

  slot_state_e      state_q;
  logic [STEP_W-1:0] step_q;
  logic [W:0]       rem_q;
  logic [W-1:0]     dvd_q;
  logic [W-1:0]     len_q;
  logic [W-1:0]     base_q;
  logic [W-1:0]     res_q;
  logic [W:0]       trial;
  logic [W:0]       rem_n;
  logic [W-1:0]     result_n;

  assign trial    = {rem_q[W-1:0], dvd_q[W-1]};
  assign rem_n    = (trial >= {1'b0, len_q}) ? (trial - {1'b0, len_q}) : trial;
  assign result_n = base_q + len_q - rem_n[W-1:0] + (len_q << 1) + len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      step_q  <= '0;
      rem_q   <= '0;
      dvd_q   <= '0;
      len_q   <= '0;
      base_q  <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        SLOT_IDLE: begin
          if (req_valid) begin
            base_q  <= cnt;
            len_q   <= len_in;
            dvd_q   <= cnt - ref_in;
            rem_q   <= '0;
            step_q  <= '0;
            state_q <= SLOT_BUSY;
          end
        end
        SLOT_BUSY: begin
          rem_q <= rem_n;
          dvd_q <= {dvd_q[W-2:0], 1'b0};
          if (step_q == LAST_STEP) begin
            res_q   <= result_n;
            state_q <= SLOT_DONE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        SLOT_DONE: begin
          if (rsp_ready) state_q <= SLOT_IDLE;
        end
        default: state_q <= SLOT_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == SLOT_IDLE);
  assign rsp_valid = (state_q == SLOT_DONE);
  assign rsp_value = res_q;
endmodule

// File: rtl/fdt_timer.sv
module fdt_timer
  import fdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_tick,
  input  logic             ext_event,
  input  logic             sw_trig,
  input  logic             start_cmd,
  input  logic             cmp_a_we,
  input  logic [CNT_W-1:0] cmp_a_val,
  input  logic             cmp_c_we,
  input  logic [CNT_W-1:0] cmp_c_val,
  input  logic [1:0]       irq_en,
  input  logic             status_rd,
  output logic [ST_W-1:0]  status,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic             counting,
  output logic             wave_out,
  input  logic             slot_req_valid,
  output logic             slot_req_ready,
  input  logic [CNT_W-1:0] slot_ref,
  input  logic [CNT_W-1:0] slot_len,
  output logic             slot_rsp_valid,
  input  logic             slot_rsp_ready,
  output logic [CNT_W-1:0] slot_rsp_value
);
  logic ext_fall;
  logic hit_a;
  logic hit_c;

  fdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (ext_event),
    .fall_pulse (ext_fall)
  );

  fdt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (carrier_tick),
    .ext_fall  (ext_fall),
    .sw_trig   (sw_trig),
    .start_cmd (start_cmd),
    .a_we      (cmp_a_we),
    .a_val     (cmp_a_val),
    .c_we      (cmp_c_we),
    .c_val     (cmp_c_val),
    .cnt       (count),
    .running   (counting),
    .wave      (wave_out),
    .hit_a     (hit_a),
    .hit_c     (hit_c)
  );

  fdt_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_a   (hit_a),
    .ev_c   (hit_c),
    .ev_ext (ext_fall),
    .rd     (status_rd),
    .ien    (irq_en),
    .flags  (status),
    .irq    (irq)
  );

  fdt_slot_calc #(.W(CNT_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (count),
    .req_valid (slot_req_valid),
    .req_ready (slot_req_ready),
    .ref_in    (slot_ref),
    .len_in    (slot_len),
    .rsp_valid (slot_rsp_valid),
    .rsp_ready (slot_rsp_ready),
    .rsp_value (slot_rsp_value)
  );
endmodule

// File: rtl/fdt_timer_chk.sv
module fdt_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_trig,
  input logic             start_cmd,
  input logic             ext_fall,
  input logic [2:0]       status,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic             counting,
  input logic             wave_out,
  input logic             slot_req_ready,
  input logic             slot_rsp_valid,
  input logic             slot_rsp_ready,
  input logic [CNT_W-1:0] slot_rsp_value
);
  AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig || start_cmd) |=> (count == '0 && counting)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    counting |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0)); // R3

  AST_EXT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> (count == '0 && counting && !wave_out && status[2])); // R4

  AST_RISE_MARKS_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_out) |-> status[0]); // R5

  AST_STOP_MARKS_C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(counting) |-> (status[1] && !wave_out)); // R6

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!counting && !sw_trig && !start_cmd && !ext_fall) |=> (!counting && $stable(count) && $stable(wave_out))); // R7

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[1] || status[2])); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_rsp_valid && !slot_rsp_ready) |=> (slot_rsp_valid && $stable(slot_rsp_value))); // R12

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_req_ready && slot_rsp_valid)); // R12
endmodule

bind fdt_timer fdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sw_trig        (sw_trig),
  .start_cmd      (start_cmd),
  .ext_fall       (ext_fall),
  .status         (status),
  .irq            (irq),
  .count          (count),
  .counting       (counting),
  .wave_out       (wave_out),
  .slot_req_ready (slot_req_ready),
  .slot_rsp_valid (slot_rsp_valid),
  .slot_rsp_ready (slot_rsp_ready),
  .slot_rsp_value (slot_rsp_value)
);

// File: tb/fdt_timer_bench.sv
`timescale 1ns/1ps
module fdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        carrier_tick = 1'b0;
  logic        ext_event = 1'b1;
  logic        sw_trig = 1'b0;
  logic        start_cmd = 1'b0;
  logic        cmp_a_we = 1'b0;
  logic [15:0] cmp_a_val = '0;
  logic        cmp_c_we = 1'b0;
  logic [15:0] cmp_c_val = '0;
  logic [1:0]  irq_en = 2'b00;
  logic        status_rd = 1'b0;
  logic [2:0]  status;
  logic        irq;
  logic [15:0] count;
  logic        counting;
  logic        wave_out;
  logic        slot_req_valid = 1'b0;
  logic        slot_req_ready;
  logic [15:0] slot_ref = '0;
  logic [15:0] slot_len = '0;
  logic        slot_rsp_valid;
  logic        slot_rsp_ready = 1'b0;
  logic [15:0] slot_rsp_value;

  always #2.5 clk = ~clk;

  fdt_timer u_fdt_timer (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_valid = 1'b0;
  bit          m_s1, m_s2, m_s3;
  logic [15:0] m_cnt, m_a, m_c;
  bit          m_run, m_wave;
  logic [2:0]  m_st;
  int          m_phase, m_steps;
  logic [15:0] exp_q[$];

  function automatic logic [15:0] slot_expect(logic [15:0] c, logic [15:0] r, logic [15:0] l);
    int diff, rem;
    diff = (int'(c) - int'(r)) & 16'hFFFF;
    rem  = (l == 0) ? diff : diff % int'(l);
    return 16'((int'(c) + int'(l) - rem + 3 * int'(l)) & 16'hFFFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cnt = 0; m_a = 0; m_c = 16'hFFFF;
      m_run = 0; m_wave = 0; m_st = 0;
      m_phase = 0; m_steps = 0;
      exp_q.delete();
      m_valid = 1'b1;
    end else begin
      bit fall, ea, ec;
      logic [15:0] old_cnt, nxt;
      old_cnt = m_cnt;
      fall = m_s3 && !m_s2;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_event;
      ea = 0; ec = 0;
      if (fall || sw_trig || start_cmd) begin
        m_cnt = 0; m_run = 1;
        if (fall || sw_trig) m_wave = 0;
      end else if (m_run && carrier_tick) begin
        nxt = m_cnt + 16'd1;
        m_cnt = nxt;
        ea = (nxt == m_a);
        ec = (nxt == m_c);
        if (ec) begin m_wave = 0; m_run = 0; end
        else if (ea) m_wave = 1;
      end
      if (cmp_a_we) m_a = cmp_a_val;
      if (cmp_c_we) m_c = cmp_c_val;
      if (status_rd) m_st = 0;
      m_st = m_st | {fall, ec, ea};
      if (m_phase == 0 && slot_req_valid) begin
        exp_q.push_back(slot_expect(old_cnt, slot_ref, slot_len));
        m_phase = 1; m_steps = 16;
      end else if (m_phase == 1) begin
        m_steps--;
        if (m_steps == 0) m_phase = 2;
      end else if (m_phase == 2 && slot_rsp_ready) begin
        m_phase = 0;
        void'(exp_q.pop_front());
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk("R3 count", count, m_cnt);
      chk("R6 counting", counting, m_run);
      chk("R5 wave_out", wave_out, m_wave);
      chk("R8 status", status, m_st);
      chk("R9 irq", irq, (m_st[1] & irq_en[0]) | (m_st[2] & irq_en[1]));
      chk("R12 slot_req_ready", slot_req_ready, m_phase == 0);
      chk("R11 slot_rsp_valid", slot_rsp_valid, m_phase == 2);
      if (m_phase == 2 && exp_q.size() > 0)
        chk("R11 slot_rsp_value", slot_rsp_value, exp_q[0]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sw();   sw_trig = 1;   cyc(1); sw_trig = 0;   endtask
  task automatic pulse_start(); start_cmd = 1; cyc(1); start_cmd = 0; endtask
  task automatic read_status(); status_rd = 1; cyc(1); status_rd = 0; endtask

  task automatic set_cmp(input logic [15:0] a, input logic [15:0] c);
    cmp_a_we = 1; cmp_a_val = a; cmp_c_we = 1; cmp_c_val = c;
    cyc(1);
    cmp_a_we = 0; cmp_c_we = 0;
  endtask

  task automatic slot_request(input logic [15:0] r, input logic [15:0] l);
    slot_ref = r; slot_len = l; slot_req_valid = 1;
    while (!slot_req_ready) cyc(1);
    cyc(1);
    slot_req_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1;
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 counting", counting, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 req_ready", slot_req_ready, 1);
    chk("R1 rsp_valid", slot_rsp_valid, 0);
    // R7: stopped counter ignores ticks
    carrier_tick = 1; cyc(5);
    chk("R7 stopped count", count, 0);

    // R1: default compare C of 0xFFFF halts the counter
    pulse_start();
    chk("R2 start count", count, 0);
    cyc(65540);
    chk("R1 default C stop", count, 16'hFFFF);
    chk("R6 halted", counting, 0);
    read_status();

    // R5/R6 with a gapped tick pattern
    set_cmp(16'd10, 16'd20);
    pulse_sw();
    for (int i = 0; i < 60; i++) begin carrier_tick = i[0]; cyc(1); end
    carrier_tick = 1;
    chk("R6 stop value", count, 20);
    chk("R6 wave low", wave_out, 0);
    chk("R5 flag A", status[0], 1);
    irq_en = 2'b11;
    cyc(1);
    chk("R9 irq on C", irq, 1);
    read_status();
    chk("R8 cleared", status, 0);

    // R6: equal compares end low
    set_cmp(16'd5, 16'd5);
    pulse_sw(); cyc(10);
    chk("R6 A==C wave", wave_out, 0);
    chk("R6 A==C count", count, 5);

    // R4: external falling edge, latency three edges
    set_cmp(16'd30, 16'd1000);
    pulse_start(); cyc(40);
    chk("R5 wave high", wave_out, 1);
    ext_event = 0; cyc(2);
    chk("R4 not yet", count == 0, 0);
    cyc(1);
    chk("R4 restart count", count, 0);
    chk("R4 wave low", wave_out, 0);
    chk("R4 flag", status[2], 1);
    cyc(5);
    ext_event = 1; cyc(5);
    chk("R4 rising ignored", count, 10);
    // R8: read in the cycle the synchronized edge lands
    ext_event = 0; cyc(2);
    read_status();
    chk("R8 same-cycle event kept", status[2], 1);
    ext_event = 1;
    irq_en = 2'b01; cyc(1);
    chk("R9 masked ext", irq, 0);
    irq_en = 2'b00;

    // R10: compare write while running
    cyc(10);
    cmp_a_we = 1; cmp_a_val = count + 16'd4; cyc(1); cmp_a_we = 0;
    read_status(); cyc(6);
    chk("R10 new A hit", status[0], 1);

    // R14: start_cmd keeps wave, sw_trig lowers it
    chk("R14 wave before", wave_out, 1);
    pulse_start();
    chk("R14 start keeps wave", wave_out, 1);
    pulse_sw();
    chk("R14 sw lowers wave", wave_out, 0);

    // R11/R12: slot requests with back-pressure
    set_cmp(16'd900, 16'd60000);
    pulse_start(); cyc(17);
    slot_rsp_ready = 0;
    slot_request(16'd3, 16'd128);
    cyc(30);
    chk("R12 held valid", slot_rsp_valid, 1);
    chk("R12 no accept", slot_req_ready, 0);
    slot_rsp_ready = 1; cyc(1); slot_rsp_ready = 0;
    slot_request(16'd500, 16'd7);
    cyc(20);
    slot_rsp_ready = 1; cyc(1);
    slot_request(16'hFFF0, 16'd1000);
    cyc(20);
    // R13: zero length returns reference
    slot_request(16'h1234, 16'd0);
    slot_rsp_ready = 0; cyc(18);
    chk("R13 zero len", slot_rsp_value, 16'h1234);
    slot_rsp_ready = 1; cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule